// File: doc/BRIEF.md
# Quadrature Mouse Motion Interface

This block connects an older-style three-button mouse to a host. It takes a ready-made motion strobe and a direction level for each axis, so it never decodes raw encoder phases. Every active edge of an axis strobe is one step of motion on that axis. The direction level captured with that edge chooses whether the signed position counter of the axis counts up or down. The three button inputs are synchronised and debounced, and the block reports them as separate state bits.

Any motion step or settled button change sets a pending flag. A level interrupt stays high while any flag is pending. The horizontal and vertical sources have separate flags, so a host that shares one interrupt line between them can still tell which one fired. The host reads one of four registers through a small read port. Reading the status register returns the pending flags and clears them in the same cycle. An event that lands on that same cycle is kept for the next read.

Top module: `quad_mouse_port`

## Requirements
- R1: After reset, both counters read 0, the button register reads 0, the status register reads 0 and `irq_o` is low.
- R2: Each active (rising) edge of `x_strobe_i` adds 1 to the X counter when `x_dir_i` is 1 (rightward) and subtracts 1 when it is 0 (leftward). Register address 0 returns X sign-extended to 16 bits.
- R3: Each rising edge of `y_strobe_i` adds 1 to the Y counter when `y_dir_i` is 1 (upward) and subtracts 1 when it is 0 (downward). Register address 1 returns Y sign-extended to 16 bits.
- R4: A strobe held high for many cycles counts as exactly one step.
- R5: The counters are 12-bit signed and saturate at +2047 (0x07FF) and -2048 (0xF800 when read) instead of wrapping.
- R6: A button bit changes only after its input has held the new level for the debounce time (DB_CYCLES clocks, 4 ms by default). A shorter pulse has no effect. Address 2 returns the buttons in bits [2:0].
- R7: Address 3 returns the status register. Bit 0 is X motion pending, bit 1 is Y motion pending and bit 2 is button change pending. `irq_o` is high while any of these bits is set.
- R8: Reading address 3 returns the pending flags and clears them. An event in the same cycle as that read stays pending and is not included in the returned value.
- R9: Read data appears on `rd_data_o` the cycle after `rd_en_i`. Reading addresses 0 to 2 leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| x_strobe_i | input | 1 | Horizontal motion strobe, asynchronous |
| x_dir_i | input | 1 | Horizontal direction, 1 means rightward |
| y_strobe_i | input | 1 | Vertical motion strobe, asynchronous |
| y_dir_i | input | 1 | Vertical direction, 1 means upward |
| btn_i | input | 3 | Raw button levels, 1 means pressed |
| rd_en_i | input | 1 | Read request |
| rd_addr_i | input | 2 | Register select: 0 X, 1 Y, 2 buttons, 3 status |
| rd_data_o | output | 16 | Registered read data |
| irq_o | output | 1 | Level interrupt, high while any flag is pending |

## Verification
The hardest case to reach is a motion step that lands on the same clock edge as a status read. The clear must not lose that step. The stimulus raises the X strobe and then issues the status read exactly two falling edges later. That count matches the two synchroniser stages, so the edge detector fires on the capturing edge. The first read must return zero and a second read must show the X flag. Saturation is reached by driving more than two thousand steps in each direction.

// File: rtl/qm_pkg.sv
package qm_pkg;
    // Number of motion axes handled by the block
    localparam int AXES = 2;
    // Pending flag bit positions in the status register
    localparam int FLG_X   = 0;
    localparam int FLG_Y   = 1;
    localparam int FLG_BTN = 2;
    localparam int NFLG    = 3;

    // Register select codes on the read port
    typedef enum logic [1:0] {
        REG_X    = 2'd0,
        REG_Y    = 2'd1,
        REG_BTN  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/qm_strobe_sync.sv
// Synchronises one axis strobe and its direction level through two flops each,
// then detects the active edge of the strobe.
// Assumes: strobe pulses last at least two clocks in each level.
module qm_strobe_sync #(
    parameter bit RISE_EDGE = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_i,
    input  logic dir_i,
    output logic step_o,
    output logic dir_o
);
    localparam logic IDLE = ~RISE_EDGE;

    logic [1:0] stb_sync;
    logic [1:0] dir_sync;
    logic       stb_prev;

    // Two-flop synchronisers plus one delayed copy of the strobe for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_sync <= {2{IDLE}};
            dir_sync <= 2'b00;
            stb_prev <= IDLE;
        end else begin
            stb_sync <= {stb_sync[0], strobe_i};
            dir_sync <= {dir_sync[0], dir_i};
            stb_prev <= stb_sync[1];
        end
    end

    generate
        if (RISE_EDGE) begin : g_rise
            assign step_o = stb_sync[1] & ~stb_prev;
        end else begin : g_fall
            assign step_o = ~stb_sync[1] & stb_prev;
        end
    endgenerate

    assign dir_o = dir_sync[1];
endmodule

// File: rtl/qm_sat_counter.sv
// Signed up/down position counter that saturates at its two limits.
// Assumes: at most one step per cycle.
module qm_sat_counter #(
    parameter int W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                up_i,
    output logic signed [W-1:0] cnt_o
);
    localparam logic signed [W-1:0] CMAX = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] CMIN = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE  = 1;

    // Count one step toward the chosen direction unless already at the limit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_o <= '0;
        end else if (step_i) begin
            if (up_i && cnt_o != CMAX) begin
                cnt_o <= cnt_o + ONE;
            end else if (!up_i && cnt_o != CMIN) begin
                cnt_o <= cnt_o - ONE;
            end
        end
    end
endmodule

// File: rtl/qm_debounce.sv
// Synchronises and debounces N button inputs. A bit takes a new level only after
// the synchronised input has differed from it for LIMIT consecutive clocks.
// Assumes: LIMIT >= 1.
module qm_debounce #(
    parameter int N     = 3,
    parameter int LIMIT = 800000
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] state_o,
    output logic         chg_o
);
    localparam int CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [N-1:0] chg_bit;

    generate
        for (genvar b = 0; b < N; b++) begin : g_btn
            logic [1:0]    sync;
            logic [CW-1:0] cnt;

            // Two-flop synchroniser for one button
            always_ff @(posedge clk) begin
                if (!rst_n) sync <= 2'b00;
                else        sync <= {sync[0], raw_i[b]};
            end

            assign chg_bit[b] = (sync[1] != state_o[b]) && (cnt == LAST);

            // Count consecutive cycles of disagreement and accept the level at the limit
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    cnt        <= '0;
                    state_o[b] <= 1'b0;
                end else if (sync[1] == state_o[b]) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt        <= '0;
                    state_o[b] <= sync[1];
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate

    assign chg_o = |chg_bit;
endmodule

// File: rtl/quad_mouse_port.sv
// Quadrature mouse motion interface: two axis step/direction paths with
// saturating counters, debounced buttons, pending flags, a level interrupt
// and a registered read port. A status read clears the flags it returns.
// Assumes: all mouse inputs are asynchronous; reads are single-cycle requests.
module quad_mouse_port #(
    parameter int CNT_W     = 12,
    parameter int NBTN      = 3,
    parameter int DB_CYCLES = 800000,
    parameter int DATA_W    = 16,
    parameter bit RISE_EDGE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              x_strobe_i,
    input  logic              x_dir_i,
    input  logic              y_strobe_i,
    input  logic              y_dir_i,
    input  logic [NBTN-1:0]   btn_i,
    input  logic              rd_en_i,
    input  logic [1:0]        rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    import qm_pkg::*;

    localparam int EXT = DATA_W - CNT_W;

    logic [AXES-1:0]         stb_in;
    logic [AXES-1:0]         dir_in;
    logic [AXES-1:0]         step;
    logic [AXES-1:0]         dir;
    logic signed [CNT_W-1:0] cnt [AXES];

    logic [NBTN-1:0]   btn_state;
    logic              btn_chg;
    logic [NFLG-1:0]   flags_q;
    logic [NFLG-1:0]   evt;
    reg_sel_e          sel;
    logic              stat_rd;
    logic [DATA_W-1:0] rd_mux;

    assign stb_in = {y_strobe_i, x_strobe_i};
    assign dir_in = {y_dir_i, x_dir_i};

    generate
        for (genvar a = 0; a < AXES; a++) begin : g_axis
            qm_strobe_sync #(.RISE_EDGE(RISE_EDGE)) u_sync (
                .clk(clk), .rst_n(rst_n),
                .strobe_i(stb_in[a]), .dir_i(dir_in[a]),
                .step_o(step[a]), .dir_o(dir[a])
            );
            qm_sat_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n),
                .step_i(step[a]), .up_i(dir[a]), .cnt_o(cnt[a])
            );
        end
    endgenerate

    qm_debounce #(.N(NBTN), .LIMIT(DB_CYCLES)) u_db (
        .clk(clk), .rst_n(rst_n), .raw_i(btn_i),
        .state_o(btn_state), .chg_o(btn_chg)
    );

    // Collect this cycle's events into flag positions
    always_comb begin
        evt          = '0;
        evt[FLG_X]   = step[0];
        evt[FLG_Y]   = step[1];
        evt[FLG_BTN] = btn_chg;
    end

    assign sel     = reg_sel_e'(rd_addr_i);
    assign stat_rd = rd_en_i && (sel == REG_STAT);

    // Pending flags: a status read replaces them with only the new events
    always_ff @(posedge clk) begin
        if (!rst_n)       flags_q <= '0;
        else if (stat_rd) flags_q <= evt;
        else              flags_q <= flags_q | evt;
    end

    // Select the register addressed by the read port
    always_comb begin
        unique case (sel)
            REG_X:    rd_mux = {{EXT{cnt[0][CNT_W-1]}}, cnt[0]};
            REG_Y:    rd_mux = {{EXT{cnt[1][CNT_W-1]}}, cnt[1]};
            REG_BTN:  rd_mux = DATA_W'(btn_state);
            default:  rd_mux = DATA_W'(flags_q);
        endcase
    end

    // Register the read data one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= rd_mux;
    end

    assign irq_o = |flags_q;
endmodule

// File: rtl/qm_checker.sv
// Property checker for quad_mouse_port, attached by bind.
module qm_checker #(
    parameter int CNT_W  = 12,
    parameter int NBTN   = 3,
    parameter int DATA_W = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    x_step,
    input logic                    x_dir,
    input logic                    y_step,
    input logic                    y_dir,
    input logic signed [CNT_W-1:0] x_cnt,
    input logic signed [CNT_W-1:0] y_cnt,
    input logic                    btn_chg,
    input logic [NBTN-1:0]         btn_state,
    input logic                    rd_en,
    input logic [1:0]              rd_addr,
    input logic [DATA_W-1:0]       rd_data,
    input logic                    irq
);
    localparam logic signed [CNT_W-1:0] CMAX = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CMIN = {1'b1, {(CNT_W-1){1'b0}}};
    localparam logic signed [CNT_W-1:0] ONE  = 1;

    p_inc_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (x_step && x_dir && x_cnt != CMAX) |=> (x_cnt == $past(x_cnt) + ONE));

    p_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (y_step && !y_dir && y_cnt != CMIN) |=> (y_cnt == $past(y_cnt) - ONE));

    p_one_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        x_step |=> !x_step);

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (x_step && x_dir && x_cnt == CMAX) |=> (x_cnt == CMAX));

    p_btn_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !btn_chg |=> $stable(btn_state));

    p_irq_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (x_step || y_step || btn_chg) |=> irq);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd3 && !x_step && !y_step && !btn_chg) |=> !irq);

    p_rd_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_addr == 2'd0) |=> (rd_data[CNT_W-1:0] == $past(x_cnt)));
endmodule

bind quad_mouse_port qm_checker #(.CNT_W(CNT_W), .NBTN(NBTN), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .x_step(step[0]), .x_dir(dir[0]), .y_step(step[1]), .y_dir(dir[1]),
    .x_cnt(cnt[0]), .y_cnt(cnt[1]),
    .btn_chg(btn_chg), .btn_state(btn_state),
    .rd_en(rd_en_i), .rd_addr(rd_addr_i), .rd_data(rd_data_o), .irq(irq_o)
);

// File: tb/quad_mouse_port_bench.sv
`timescale 1ns/1ps
module quad_mouse_port_bench;
    localparam int DB = 20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        x_strobe, x_dir, y_strobe, y_dir;
    logic [2:0]  btn;
    logic        rd_en;
    logic [1:0]  rd_addr;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad   = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic        rd_seen = 1'b0;

    always #2.5 clk = ~clk;

    quad_mouse_port #(.DB_CYCLES(DB)) u_quad_mouse_port (
        .clk(clk), .rst_n(rst_n),
        .x_strobe_i(x_strobe), .x_dir_i(x_dir),
        .y_strobe_i(y_strobe), .y_dir_i(y_dir),
        .btn_i(btn), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: note reads at the edge, compare on the following falling edge
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                check("scoreboard empty", rd_data, 16'hxxxx);
            end else begin
                check(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    // Driver: push expectation and issue a one-cycle read
    task automatic rd(input logic [1:0] a, input logic [15:0] e, input string tag);
        rd_addr = a;
        rd_en   = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic move(input bit axis, input bit d, input int hold);
        if (axis) begin y_dir = d; y_strobe = 1'b1; end
        else      begin x_dir = d; x_strobe = 1'b1; end
        repeat (hold) @(negedge clk);
        if (axis) y_strobe = 1'b0; else x_strobe = 1'b0;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; x_strobe = 0; x_dir = 0; y_strobe = 0; y_dir = 0;
        btn = 3'b000; rd_en = 0; rd_addr = 2'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq", {15'b0, irq}, 16'h0000);
        rd(2'd0, 16'h0000, "R1 X");
        rd(2'd1, 16'h0000, "R1 Y");
        rd(2'd2, 16'h0000, "R1 buttons");
        rd(2'd3, 16'h0000, "R1 status");

        // R2 rightward and leftward steps
        repeat (5) move(1'b0, 1'b1, 2);
        repeat (2) move(1'b0, 1'b0, 2);
        rd(2'd0, 16'h0003, "R2 X count");
        check("R7 irq pending", {15'b0, irq}, 16'h0001);
        rd(2'd3, 16'h0001, "R7 X flag");
        check("R8 irq cleared", {15'b0, irq}, 16'h0000);
        rd(2'd3, 16'h0000, "R8 flags cleared");

        // R3 upward and downward steps
        repeat (4) move(1'b1, 1'b1, 2);
        repeat (6) move(1'b1, 1'b0, 2);
        rd(2'd1, 16'hFFFE, "R3 Y count");
        rd(2'd3, 16'h0002, "R7 Y flag");

        // R4 long strobe counts once
        x_dir = 1'b1; x_strobe = 1'b1;
        repeat (20) @(negedge clk);
        x_strobe = 1'b0;
        repeat (4) @(negedge clk);
        rd(2'd0, 16'h0004, "R4 single step");
        rd(2'd3, 16'h0001, "R4 flag");

        // R9 non-status reads keep flags
        move(1'b1, 1'b1, 2);
        rd(2'd0, 16'h0004, "R9 X read");
        rd(2'd1, 16'hFFFF, "R9 Y read");
        rd(2'd3, 16'h0002, "R9 flag kept");

        // R6 short glitch ignored
        btn = 3'b010;
        repeat (5) @(negedge clk);
        btn = 3'b000;
        repeat (30) @(negedge clk);
        rd(2'd2, 16'h0000, "R6 glitch buttons");
        rd(2'd3, 16'h0000, "R6 glitch status");
        check("R6 irq after glitch", {15'b0, irq}, 16'h0000);

        // R6 held press and release
        btn = 3'b010;
        repeat (40) @(negedge clk);
        rd(2'd2, 16'h0002, "R6 press");
        rd(2'd3, 16'h0004, "R7 button flag");
        btn = 3'b000;
        repeat (40) @(negedge clk);
        rd(2'd2, 16'h0000, "R6 release");
        rd(2'd3, 16'h0004, "R6 release flag");

        // R8 step lands on the same edge as the status read
        x_dir = 1'b1; x_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rd(2'd3, 16'h0000, "R8 same-cycle read");
        x_strobe = 1'b0;
        repeat (3) @(negedge clk);
        rd(2'd3, 16'h0001, "R8 same-cycle event kept");
        rd(2'd0, 16'h0005, "R8 X count");

        // R5 saturation at both limits
        repeat (2100) move(1'b0, 1'b1, 2);
        rd(2'd0, 16'h07FF, "R5 upper limit");
        repeat (4200) move(1'b0, 1'b0, 2);
        rd(2'd0, 16'hF800, "R5 lower limit");

        repeat (4) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule